// File: doc/BRIEF.md
# Capture/Compare/PWM Timer Channel

One timer channel built around a 16-bit data register that software reaches one byte at a time. A 4-bit mode code in a control register picks the function. In capture mode the channel copies an external 16-bit free-running timebase into the data register on a chosen edge of a synchronised input pin. In compare mode it watches the same timebase for equality with the data register. On a match it can set or clear the output pin, only raise the interrupt flag, or issue a special event strobe that clears the shared timebase. In PWM mode it uses a separate 8-bit period timer to drive a pulse-width waveform, and takes duty changes through a shadow register.

The timers and the converter sit outside the block and appear as ports. Two instances normally share one timebase and one period timer. The instance built with `SECOND_CH = 1` also asks for a converter start together with its special event strobe, when the converter is enabled.

Top module: `ccp_channel`

## Requirements
- R1: The register port decodes `reg_addr` 0 as the low data byte, 1 as the high data byte and 2 as control. Control bits 3:0 hold the mode code and bits 7:4 read as zero. Address 3 reads zero. A write takes effect on the clock edge where `reg_we` is high, and `reg_rdata` follows `reg_addr` combinationally.
- R2: After reset both data bytes, the mode code (0000), `out_pin`, `irq_flag`, `tb_clear` and `adc_start` are all zero.
- R3: Mode 0101 captures on rising edges of `cap_pin` and mode 0100 on falling edges. The pin passes through two flip-flops. The capture loads the `tb_count` value present at the third rising clock edge after the pin changes into both bytes at that same edge, and sets `irq_flag` there. An edge of the opposite direction captures nothing.
- R4: Mode 0110 captures on every fourth rising edge and mode 0111 on every sixteenth. A write to the control register restarts the edge count.
- R5: Modes 1000 to 1011 detect a match when `tb_count` equals {high byte, low byte}. Only the first cycle of equality is an event. A new event needs at least one cycle of inequality first.
- R6: Writing mode 1000 sets `out_pin` low and a match then drives it high. Writing mode 1001 sets it high and a match drives it low. Modes 1010 and 1011 keep the pin low.
- R7: In mode 1011 a match drives `tb_clear` high for exactly one cycle, starting at the same edge that sets `irq_flag`.
- R8: With `SECOND_CH = 1`, `adc_start` pulses together with `tb_clear` when `adc_en` is high at the match. With `SECOND_CH = 0` it never rises.
- R9: In mode 1100, at each edge where `per_rollover` is high, `out_pin` goes high if the shadow duty is nonzero and low if it is zero. It goes low at a later edge where `per_count` equals the active duty. A duty that the period timer never reaches keeps the pin high.
- R10: In mode 1100 the low byte is the shadow duty. It is copied into the active duty only at a rollover edge. A high-byte read returns the active duty, and high-byte writes are ignored.
- R11: `irq_flag` stays set until an `irq_clr` pulse. An event in the same cycle as the clear leaves it set.
- R12: Mode 0000 and the undefined codes (0001 to 0011, 1101 to 1111) keep `out_pin` low, never set `irq_flag` and never pulse `tb_clear` or `adc_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 low, 1 high, 2 control |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| tb_count | input | 16 | Shared free-running timebase value |
| per_count | input | 8 | Period timer value |
| per_rollover | input | 1 | High in the cycle the period timer wraps to zero |
| cap_pin | input | 1 | Asynchronous capture input |
| out_pin | output | 1 | Compare or PWM output |
| irq_flag | output | 1 | Sticky event flag |
| irq_clr | input | 1 | Flag clear strobe |
| tb_clear | output | 1 | One-cycle timebase clear request |
| adc_en | input | 1 | Converter enabled |
| adc_start | output | 1 | One-cycle conversion start request |

## Verification
A wrong synchroniser depth or a stale edge register shows up as a capture one clock early or late, so the stored timebase value differs from the value that was driven three edges after the pin change. A compare match register that holds the wrong value either repeats the flag while the timebase is held equal, or misses the next match. In PWM mode a stale active duty shows on the high-byte read straight away, and on the pin within one period, because the falling edge of the waveform lands in the wrong cycle.

// File: rtl/ccp_pkg.sv
`timescale 1ns/1ps
package ccp_pkg;

   typedef enum logic [3:0] {
      MODE_OFF        = 4'h0,
      MODE_CAP_FALL   = 4'h4,
      MODE_CAP_RISE   = 4'h5,
      MODE_CAP_RISE4  = 4'h6,
      MODE_CAP_RISE16 = 4'h7,
      MODE_CMP_SET    = 4'h8,
      MODE_CMP_CLR    = 4'h9,
      MODE_CMP_IRQ    = 4'hA,
      MODE_CMP_TRIG   = 4'hB,
      MODE_PWM        = 4'hC
   } ccp_mode_e;

   localparam logic [1:0] ADDR_LO   = 2'd0;
   localparam logic [1:0] ADDR_HI   = 2'd1;
   localparam logic [1:0] ADDR_CTRL = 2'd2;

   function automatic logic is_capture(input logic [3:0] m);
      return (m == MODE_CAP_FALL) || (m == MODE_CAP_RISE) ||
             (m == MODE_CAP_RISE4) || (m == MODE_CAP_RISE16);
   endfunction

   function automatic logic is_compare(input logic [3:0] m);
      return (m == MODE_CMP_SET) || (m == MODE_CMP_CLR) ||
             (m == MODE_CMP_IRQ) || (m == MODE_CMP_TRIG);
   endfunction

   function automatic logic is_pwm(input logic [3:0] m);
      return m == MODE_PWM;
   endfunction

endpackage

// File: rtl/ccp_capture_unit.sv
`timescale 1ns/1ps
module ccp_capture_unit
   import ccp_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int PRESC_W     = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [3:0] mode,
   input  logic       restart,
   input  logic       pin,
   output logic       cap_evt
);

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic [PRESC_W-1:0]     presc_q;
   logic                   pin_s, rise, fall, step;

   // synchroniser chain, depth chosen by parameter
   generate
      if (SYNC_STAGES == 1) begin : g_sync1
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) sync_q <= '0;
            else        sync_q <= pin;
      end else begin : g_syncn
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) sync_q <= '0;
            else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
      end
   endgenerate

   assign pin_s = sync_q[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= pin_s;

   assign rise = pin_s & ~prev_q;
   assign fall = ~pin_s & prev_q;
   assign step = rise & ((mode == MODE_CAP_RISE4) || (mode == MODE_CAP_RISE16));

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)       presc_q <= '0;
      else if (restart) presc_q <= '0;
      else if (step)    presc_q <= presc_q + 1'b1;

   always_comb begin
      case (mode)
         MODE_CAP_FALL:   cap_evt = fall;
         MODE_CAP_RISE:   cap_evt = rise;
         MODE_CAP_RISE4:  cap_evt = rise && (presc_q[1:0] == 2'b11);
         MODE_CAP_RISE16: cap_evt = rise && (presc_q[3:0] == 4'hF);
         default:         cap_evt = 1'b0;
      endcase
   end

   // R3: a capture only happens while a capture code is selected
   a_r3_evt_in_capture: assert property (@(posedge clk) disable iff (!rst_n)
      cap_evt |-> is_capture(mode));

   // R4: the edge count never moves outside the prescaled codes
   a_r4_count_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (!restart && mode != MODE_CAP_RISE4 && mode != MODE_CAP_RISE16) |=> $stable(presc_q));

endmodule

// File: rtl/ccp_compare_unit.sv
`timescale 1ns/1ps
module ccp_compare_unit #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic [DATA_W-1:0] tb,
   input  logic [DATA_W-1:0] ref_val,
   output logic              hit
);

   logic match, match_q;

   assign match = enable && (tb == ref_val);

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) match_q <= 1'b0;
      else        match_q <= match;

   assign hit = match & ~match_q;

   // R5: a match event never repeats on the next cycle
   a_r5_single_event: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> !hit);

endmodule

// File: rtl/ccp_pwm_unit.sv
`timescale 1ns/1ps
module ccp_pwm_unit #(
   parameter int PER_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic [PER_W-1:0] per_count,
   input  logic             per_roll,
   input  logic [PER_W-1:0] shadow,
   output logic             pwm_out,
   output logic [PER_W-1:0] active
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pwm_out <= 1'b0;
         active  <= '0;
      end else if (!enable) begin
         pwm_out <= 1'b0;
      end else if (per_roll) begin
         active  <= shadow;
         pwm_out <= (shadow != '0);
      end else if (per_count == active) begin
         pwm_out <= 1'b0;
      end
   end

   // R9: a zero duty keeps the pulse from starting
   a_r9_zero_duty: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && per_roll && shadow == '0) |=> !pwm_out);

   // R10: the active duty changes only at a rollover
   a_r10_active_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(enable && per_roll) |=> $stable(active));

endmodule

// File: rtl/ccp_channel.sv
`timescale 1ns/1ps
module ccp_channel
   import ccp_pkg::*;
#(
   parameter int BYTE_W      = 8,
   parameter int PER_W       = 8,
   parameter int SYNC_STAGES = 2,
   parameter int PRESC_W     = 4,
   parameter bit SECOND_CH   = 1'b0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_we,
   input  logic [1:0]  reg_addr,
   input  logic [7:0]  reg_wdata,
   output logic [7:0]  reg_rdata,
   input  logic [15:0] tb_count,
   input  logic [7:0]  per_count,
   input  logic        per_rollover,
   input  logic        cap_pin,
   output logic        out_pin,
   output logic        irq_flag,
   input  logic        irq_clr,
   output logic        tb_clear,
   input  logic        adc_en,
   output logic        adc_start
);

   localparam int DATA_W = 2 * BYTE_W;

   initial begin
      if (BYTE_W != 8)     $fatal(1, "ccp_channel: BYTE_W must match the 8-bit register port");
      if (PER_W > BYTE_W)  $fatal(1, "ccp_channel: PER_W must fit in one byte");
      if (SYNC_STAGES < 2) $fatal(1, "ccp_channel: SYNC_STAGES must be at least 2");
      if (PRESC_W < 4)     $fatal(1, "ccp_channel: PRESC_W must be at least 4");
   end

   logic [BYTE_W-1:0] lo_q, hi_q;
   logic [3:0]        mode_q;
   logic              irq_q, pin_q, tbclr_q;
   logic              we_lo, we_hi, we_ctrl;
   logic              cap_evt, cmp_hit, pwm_out;
   logic [PER_W-1:0]  active;
   logic [BYTE_W-1:0] active_ext;
   logic              cmp_pin_mode;

   assign we_lo   = reg_we && (reg_addr == ADDR_LO);
   assign we_hi   = reg_we && (reg_addr == ADDR_HI);
   assign we_ctrl = reg_we && (reg_addr == ADDR_CTRL);

   ccp_capture_unit #(
      .SYNC_STAGES (SYNC_STAGES),
      .PRESC_W     (PRESC_W)
   ) u_cap (
      .clk     (clk),
      .rst_n   (rst_n),
      .mode    (mode_q),
      .restart (we_ctrl),
      .pin     (cap_pin),
      .cap_evt (cap_evt)
   );

   ccp_compare_unit #(
      .DATA_W (DATA_W)
   ) u_cmp (
      .clk     (clk),
      .rst_n   (rst_n),
      .enable  (is_compare(mode_q)),
      .tb      (tb_count),
      .ref_val ({hi_q, lo_q}),
      .hit     (cmp_hit)
   );

   ccp_pwm_unit #(
      .PER_W (PER_W)
   ) u_pwm (
      .clk       (clk),
      .rst_n     (rst_n),
      .enable    (is_pwm(mode_q)),
      .per_count (per_count[PER_W-1:0]),
      .per_roll  (per_rollover),
      .shadow    (lo_q[PER_W-1:0]),
      .pwm_out   (pwm_out),
      .active    (active)
   );

   // data register: a capture beats a software write in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q <= '0;
         hi_q <= '0;
      end else if (cap_evt) begin
         lo_q <= tb_count[BYTE_W-1:0];
         hi_q <= tb_count[DATA_W-1:BYTE_W];
      end else begin
         if (we_lo) lo_q <= reg_wdata;
         if (we_hi && !is_pwm(mode_q)) hi_q <= reg_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)       mode_q <= MODE_OFF;
      else if (we_ctrl) mode_q <= reg_wdata[3:0];

   // compare output level
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pin_q <= 1'b0;
      else if (we_ctrl) pin_q <= (reg_wdata[3:0] == MODE_CMP_CLR);
      else if (cmp_hit) begin
         if (mode_q == MODE_CMP_SET)      pin_q <= 1'b1;
         else if (mode_q == MODE_CMP_CLR) pin_q <= 1'b0;
      end
   end

   assign cmp_pin_mode = (mode_q == MODE_CMP_SET) || (mode_q == MODE_CMP_CLR);

   always_comb begin
      if (is_pwm(mode_q))    out_pin = pwm_out;
      else if (cmp_pin_mode) out_pin = pin_q;
      else                   out_pin = 1'b0;
   end

   // sticky flag, events win over the clear
   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                  irq_q <= 1'b0;
      else if (cap_evt || cmp_hit) irq_q <= 1'b1;
      else if (irq_clr)            irq_q <= 1'b0;

   assign irq_flag = irq_q;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) tbclr_q <= 1'b0;
      else        tbclr_q <= cmp_hit && (mode_q == MODE_CMP_TRIG);

   assign tb_clear = tbclr_q;

   generate
      if (SECOND_CH) begin : g_adc
         logic adc_q;
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) adc_q <= 1'b0;
            else        adc_q <= cmp_hit && (mode_q == MODE_CMP_TRIG) && adc_en;
         assign adc_start = adc_q;
      end else begin : g_no_adc
         assign adc_start = 1'b0;
      end
   endgenerate

   always_comb begin
      active_ext = '0;
      active_ext[PER_W-1:0] = active;
   end

   always_comb begin
      case (reg_addr)
         ADDR_LO:   reg_rdata = lo_q;
         ADDR_HI:   reg_rdata = is_pwm(mode_q) ? active_ext : hi_q;
         ADDR_CTRL: reg_rdata = {4'b0000, mode_q};
         default:   reg_rdata = 8'h00;
      endcase
   end

   // R11: any event leaves the flag set on the next cycle
   a_r11_event_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_evt || cmp_hit) |=> irq_flag);

   // R7: the timebase clear strobe lasts one cycle
   a_r7_clear_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      tb_clear |=> !tb_clear);

   // R8: a conversion start only comes with a timebase clear
   a_r8_adc_with_clear: assert property (@(posedge clk) disable iff (!rst_n)
      adc_start |-> tb_clear);

   // R6: a set-on-match event drives the pin high
   a_r6_set_drives_high: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_hit && mode_q == MODE_CMP_SET && !we_ctrl) |=> out_pin);

   // R12: without a live mode the flag cannot rise
   a_r12_quiet_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (!is_capture(mode_q) && !is_compare(mode_q)) |=> !$rose(irq_flag));

endmodule

// File: tb/sim_ccp_channel.sv
`timescale 1ns/1ps
module sim_ccp_channel;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        we = 1'b0;
   logic [1:0]  addr = 2'd0;
   logic [7:0]  wdata = 8'h00;
   logic [15:0] tb = 16'h0000;
   logic [7:0]  per_cnt = 8'h00;
   logic        per_roll = 1'b0;
   logic        cap = 1'b0;
   logic        irq_clr = 1'b0;
   logic        adc_en = 1'b0;
   logic [7:0]  rdata0, rdata1;
   logic        out0, irq0, tbclr0, adc0;
   logic        out1, irq1, tbclr1, adc1;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   ccp_channel #(.SECOND_CH(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .reg_we(we), .reg_addr(addr), .reg_wdata(wdata),
      .reg_rdata(rdata0), .tb_count(tb), .per_count(per_cnt), .per_rollover(per_roll),
      .cap_pin(cap), .out_pin(out0), .irq_flag(irq0), .irq_clr(irq_clr),
      .tb_clear(tbclr0), .adc_en(adc_en), .adc_start(adc0));

   ccp_channel #(.SECOND_CH(1'b0)) u1 (
      .clk(clk), .rst_n(rst_n), .reg_we(we), .reg_addr(addr), .reg_wdata(wdata),
      .reg_rdata(rdata1), .tb_count(tb), .per_count(per_cnt), .per_rollover(per_roll),
      .cap_pin(cap), .out_pin(out1), .irq_flag(irq1), .irq_clr(irq_clr),
      .tb_clear(tbclr1), .adc_en(adc_en), .adc_start(adc1));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      we = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      addr = a;
      #1 d = rdata0;
   endtask

   task automatic clear_flag();
      irq_clr = 1'b1;
      @(negedge clk);
      irq_clr = 1'b0;
   endtask

   function automatic logic [15:0] pick16();
      logic [15:0] v;
      v = 16'($urandom_range(16, 16'hFFEF));
      return v;
   endfunction

   // expected PWM level after one edge, from the requirement text
   function automatic logic pwm_next(input logic cur, input logic roll,
                                     input logic [7:0] cnt, input logic [7:0] act,
                                     input logic [7:0] shd);
      if (roll)            return shd != 8'h00;
      else if (cnt == act) return 1'b0;
      else                 return cur;
   endfunction

   task automatic pulse();
      cap = 1'b1; tick(3);
      cap = 1'b0; tick(3);
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [7:0]  d;
      logic [15:0] v, t;
      void'($urandom(32'h1234_5678));
      tick(3);
      rst_n = 1'b1;
      tick(1);

      // R2 reset state
      rd(2'd0, d); chk("R2 low", d, 0);
      rd(2'd1, d); chk("R2 high", d, 0);
      rd(2'd2, d); chk("R2 ctrl", d, 0);
      chk("R2 pins", {out0, irq0, tbclr0, adc0}, 0);

      // R1 byte access with random data
      for (int i = 0; i < 6; i++) begin
         v = 16'($urandom);
         wr(2'd0, v[7:0]); wr(2'd1, v[15:8]);
         rd(2'd0, d); chk("R1 low", d, v[7:0]);
         rd(2'd1, d); chk("R1 high", d, v[15:8]);
      end
      wr(2'd2, 8'hF3);
      rd(2'd2, d); chk("R1 ctrl upper zero", d, 8'h03);
      rd(2'd3, d); chk("R1 addr3", d, 0);

      // R12 undefined code 0011: matching timebase and pin edges do nothing
      wr(2'd0, 8'h34); wr(2'd1, 8'h12);
      tb = 16'h1233; tick(1); tb = 16'h1234;
      for (int i = 0; i < 6; i++) begin cap = ~cap; tick(1); end
      cap = 1'b0; tick(4);
      chk("R12 quiet", {out0, irq0, tbclr0, adc0}, 0);
      wr(2'd2, 8'h00); tick(2);
      chk("R12 off", {out0, irq0}, 0);

      // R5/R6 set-on-match, held equality and rematch
      v = pick16();
      tb = v - 16'd5;
      wr(2'd0, v[7:0]); wr(2'd1, v[15:8]);
      wr(2'd2, 8'h08);
      chk("R6 set mode init low", out0, 0);
      for (int i = 0; i < 4; i++) begin tb = tb + 16'd1; tick(1); end
      chk("R5 no early match", irq0, 0);
      tb = v; tick(1);
      chk("R5 match flag", irq0, 1);
      chk("R6 set drives high", out0, 1);
      clear_flag(); tick(2);
      chk("R5 once per match", irq0, 0);
      tb = v + 16'd1; tick(1); tb = v; tick(1);
      chk("R5 rematch", irq0, 1);
      clear_flag();

      // R6 clear-on-match
      tb = v - 16'd3;
      wr(2'd2, 8'h09);
      chk("R6 clear mode init high", out0, 1);
      tb = v; tick(1);
      chk("R6 clear drives low", out0, 0);
      clear_flag();

      // R11 event wins over simultaneous clear, interrupt-only keeps pin low
      tb = v - 16'd1;
      wr(2'd2, 8'h0A); tick(1);
      tb = v; irq_clr = 1'b1; tick(1); irq_clr = 1'b0;
      chk("R11 event wins", irq0, 1);
      chk("R6 irq-only pin low", out0, 0);
      tick(3);
      chk("R11 sticky", irq0, 1);
      clear_flag();
      chk("R11 cleared", irq0, 0);

      // R5 random compare values
      for (int i = 0; i < 16; i++) begin
         v = pick16();
         tb = v - 16'd2;
         wr(2'd0, v[7:0]); wr(2'd1, v[15:8]);
         tb = v - 16'd1; tick(1);
         chk("R5 random pre", irq0, 0);
         tb = v; tick(1);
         chk("R5 random hit", irq0, 1);
         clear_flag();
      end

      // R7/R8 special event strobe
      v = pick16();
      tb = v - 16'd1;
      wr(2'd0, v[7:0]); wr(2'd1, v[15:8]);
      wr(2'd2, 8'h0B);
      adc_en = 1'b1;
      tb = v; tick(1);
      chk("R7 clear strobe", tbclr0, 1);
      chk("R8 adc on second", adc0, 1);
      chk("R8 no adc on first", adc1, 0);
      chk("R6 trig pin low", out0, 0);
      tb = 16'h0000; tick(1);
      chk("R7 one cycle", tbclr0, 0);
      chk("R8 adc one cycle", adc0, 0);
      adc_en = 1'b0;
      tb = v; tick(1);
      chk("R7 clear again", tbclr0, 1);
      chk("R8 adc gated", adc0, 0);
      tb = 16'h0000; clear_flag();

      // R3 rising edge capture and its latency
      wr(2'd2, 8'h05);
      tb = 16'h1111; cap = 1'b1; tick(2);
      chk("R3 not yet", irq0, 0);
      t = 16'hBEEF; tb = t; tick(1);
      chk("R3 rise flag", irq0, 1);
      tb = 16'h2222; tick(1);
      rd(2'd0, d); chk("R3 rise low", d, t[7:0]);
      rd(2'd1, d); chk("R3 rise high", d, t[15:8]);
      clear_flag();
      cap = 1'b0; tick(5);
      chk("R3 falling ignored", irq0, 0);

      // R3 falling edge capture
      wr(2'd2, 8'h04);
      cap = 1'b1; tick(5);
      chk("R3 rising ignored", irq0, 0);
      t = 16'h5A5A; tb = t; cap = 1'b0; tick(3);
      chk("R3 fall flag", irq0, 1);
      rd(2'd0, d); chk("R3 fall low", d, t[7:0]);
      rd(2'd1, d); chk("R3 fall high", d, t[15:8]);
      clear_flag();

      // R4 every fourth and every sixteenth rising edge
      wr(2'd2, 8'h06);
      for (int i = 0; i < 3; i++) begin tb = 16'(16'h0100 + i); pulse(); end
      chk("R4 quarter wait", irq0, 0);
      t = 16'h0A0B; tb = t; pulse();
      chk("R4 quarter flag", irq0, 1);
      rd(2'd0, d); chk("R4 quarter low", d, t[7:0]);
      clear_flag();
      pulse(); pulse();
      wr(2'd2, 8'h06);
      pulse(); pulse(); pulse();
      chk("R4 restart", irq0, 0);
      pulse();
      chk("R4 restart fourth", irq0, 1);
      clear_flag();
      wr(2'd2, 8'h07);
      for (int i = 0; i < 15; i++) pulse();
      chk("R4 sixteenth wait", irq0, 0);
      t = 16'hC0DE; tb = t; pulse();
      chk("R4 sixteenth flag", irq0, 1);
      rd(2'd1, d); chk("R4 sixteenth high", d, t[15:8]);
      clear_flag();

      // R9/R10 PWM against a bench model
      begin
         logic [7:0] act, shd, duty, period;
         logic       exp;
         act = 8'h00; exp = 1'b0;
         shd = 8'h00;
         wr(2'd0, 8'h00);
         wr(2'd2, 8'h0C);
         per_cnt = 8'h00;
         for (int seg = 0; seg < 6; seg++) begin
            period = 8'($urandom_range(4, 20));
            if (seg == 0)      duty = 8'h00;
            else if (seg == 1) duty = period + 8'd2;
            else               duty = 8'($urandom_range(1, period - 1));
            for (int c = 0; c < 3 * period; c++) begin
               logic [7:0] nc;
               logic       nr;
               chk("R9 pwm level", out0, exp);
               addr = 2'd1;
               #1 chk("R10 active readback", rdata0, act);
               nc = (per_cnt >= period - 8'd1) ? 8'h00 : per_cnt + 8'd1;
               nr = (nc == 8'h00);
               per_cnt = nc; per_roll = nr;
               if (c == 1) begin
                  we = 1'b1; addr = 2'd0; wdata = duty;
               end else if (c == 2) begin
                  we = 1'b1; addr = 2'd1; wdata = 8'hEE;
               end else begin
                  we = 1'b0; addr = 2'd1;
               end
               exp = pwm_next(exp, nr, nc, act, shd);
               if (nr) act = shd;
               if (c == 1) shd = duty;
               @(negedge clk);
            end
            we = 1'b0;
         end
         per_roll = 1'b0;
      end

      wr(2'd2, 8'h00); tick(1);
      chk("R12 off after pwm", out0, 0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule